// File: doc/BRIEF.md
# Signed Leaky Integrate-and-Fire Pixel

This block is the digital model of one cell in an event-driven convolution array. Before every integration pulse, the controller loads the cell with one signed kernel weight. When the global integration pulse arrives, the cell compares the sign of the current input event with the sign of the stored weight. If the signs agree, the weight magnitude is added to a signed membrane accumulator. If they differ, the magnitude is subtracted.

The accumulator is checked against two programmable limits, one positive and one negative. When it reaches either limit, the cell snaps back to rest (zero) and raises a request, tagged with the polarity of the limit it reached. The request stays up until an acknowledge comes back. A separate global forget strobe pulls the accumulator toward rest, so that only events close together in time can build up to a firing.

Top module: `lif_pixel`

## Requirements
- R1: The weight word is 4 bits wide. Bit 3 is the sign (1 = negative) and bits 2:0 are the magnitude. A load replaces the stored weight from the next cycle on, so an integration pulse in the same cycle as a load uses the old weight.
- R2: On an integration pulse, the accumulator gains the weight magnitude when the event sign (`evt_neg`) equals the weight sign, and loses it when the signs differ. The new value is visible on `acc_out` one cycle later.
- R3: When an integration result is at or above `thr_pos`, the cell fires positive (`col_pos` high). When it is at or below `thr_neg`, the cell fires negative (`col_neg` high). In both cases `row_req` rises in the cycle after the pulse.
- R4: A firing integration leaves the accumulator at exactly 0.
- R5: A forget strobe moves a nonzero accumulator toward 0 by LEAK_STEP (default 2) and clamps at 0 if the step would overshoot. A forget strobe with the accumulator at 0 leaves it at 0.
- R6: `row_req` and the active column line stay high until `fire_ack` is seen high. They clear in the cycle after that.
- R7: While `row_req` is high, integration pulses and forget strobes have no effect on the accumulator.
- R8: When an integration pulse and a forget strobe arrive in the same cycle, only the integration is applied.
- R9: After reset the accumulator is 0, no request is raised, and the stored weight is +0.
- R10: `fire_ack` with no request pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_load | input | 1 | Load `wt_in` into the weight register |
| wt_in | input | 4 | Weight word: sign in bit 3, magnitude in bits 2:0 |
| integ_pulse | input | 1 | Global integration pulse |
| evt_neg | input | 1 | Sign of the current input event (1 = negative) |
| forget | input | 1 | Global forget strobe |
| thr_pos | input | 16 | Positive firing limit (signed) |
| thr_neg | input | 16 | Negative firing limit (signed) |
| fire_ack | input | 1 | Acknowledge from the row arbiter |
| row_req | output | 1 | Pending fire request |
| col_pos | output | 1 | Pending request is positive |
| col_neg | output | 1 | Pending request is negative |
| acc_out | output | 16 | Membrane accumulator (signed) |

## Verification
The assertions assume that `thr_pos` is positive and `thr_neg` is negative, and that both stay far enough inside the 16-bit range that one weight step cannot wrap the accumulator. Under those conditions the accumulator always lies strictly between the limits whenever no request is pending.

The stimulus holds the thresholds constant over each run segment and picks them from small positive and negative values only. Inside those fixed limits, the random traffic is free to load weights, pulse, forget and acknowledge in any combination, including acknowledges with nothing pending.

// File: rtl/lif_pkg.sv
package lif_pkg;

  // Signed step applied by one integration pulse.
  function automatic int weight_delta(input logic ev_neg, input logic w_neg, input int mag);
    return (ev_neg == w_neg) ? mag : -mag;
  endfunction

  // One leak step toward zero that never crosses zero.
  function automatic int leak_toward_rest(input int v, input int step);
    int r;
    if (v > 0)      r = (v > step) ? v - step : 0;
    else if (v < 0) r = (-v > step) ? v + step : 0;
    else            r = 0;
    return r;
  endfunction

endpackage

// File: rtl/lif_weight_reg.sv
module lif_weight_reg #(
  parameter int MAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MAG_W:0]   din,
  output logic             w_neg,
  output logic [MAG_W-1:0] w_mag
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_neg <= 1'b0;
      w_mag <= '0;
    end else if (load) begin
      w_neg <= din[MAG_W];
      w_mag <= din[MAG_W-1:0];
    end
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (w_neg == $past(din[MAG_W])) && (w_mag == $past(din[MAG_W-1:0]))); // R1

endmodule

// File: rtl/lif_integrator.sv
module lif_integrator #(
  parameter int ACC_W     = 16,
  parameter int MAG_W     = 3,
  parameter int LEAK_STEP = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    integ_go,
  input  logic                    forget_go,
  input  logic                    ev_neg,
  input  logic                    w_neg,
  input  logic [MAG_W-1:0]        w_mag,
  input  logic signed [ACC_W-1:0] thr_pos,
  input  logic signed [ACC_W-1:0] thr_neg,
  output logic signed [ACC_W-1:0] acc,
  output logic                    fire_pos,
  output logic                    fire_neg
);

  int delta;
  int sum;
  logic signed [ACC_W-1:0] acc_n;

  always_comb begin
    delta    = lif_pkg::weight_delta(ev_neg, w_neg, int'(w_mag));
    sum      = int'(acc) + delta;
    fire_pos = integ_go && (sum >= int'(thr_pos));
    fire_neg = integ_go && !fire_pos && (sum <= int'(thr_neg));
    acc_n    = acc;
    if (integ_go)
      acc_n = (fire_pos || fire_neg) ? '0 : ACC_W'(sum);
    else if (forget_go)
      acc_n = ACC_W'(lif_pkg::leak_toward_rest(int'(acc), LEAK_STEP));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_n;
  end

  AST_FIRE_RESTS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_pos || fire_neg) |=> (acc == '0)); // R4
  AST_LEAK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (forget_go && !integ_go && acc > 0) |=> (acc >= 0) && (acc < $past(acc))); // R5
  AST_LEAK_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (forget_go && !integ_go && acc < 0) |=> (acc <= 0) && (acc > $past(acc))); // R5
  AST_SAME_SIGN_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_go && !fire_pos && !fire_neg && ev_neg == w_neg) |=> (acc >= $past(acc))); // R2

endmodule

// File: rtl/lif_fire_hs.sv
module lif_fire_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_pos,
  input  logic fire_neg,
  input  logic ack,
  output logic req,
  output logic col_pos,
  output logic col_neg
);

  logic pol_pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req     <= 1'b0;
      pol_pos <= 1'b0;
    end else if (req) begin
      if (ack) req <= 1'b0;
    end else if (fire_pos || fire_neg) begin
      req     <= 1'b1;
      pol_pos <= fire_pos;
    end
  end

  assign col_pos = req & pol_pos;
  assign col_neg = req & ~pol_pos;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(col_pos))); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack) |=> !req); // R6
  AST_POS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && fire_pos) |=> col_pos); // R3

endmodule

// File: rtl/lif_pixel.sv
module lif_pixel #(
  parameter int ACC_W     = 16,
  parameter int MAG_W     = 3,
  parameter int LEAK_STEP = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wt_load,
  input  logic [MAG_W:0]          wt_in,
  input  logic                    integ_pulse,
  input  logic                    evt_neg,
  input  logic                    forget,
  input  logic signed [ACC_W-1:0] thr_pos,
  input  logic signed [ACC_W-1:0] thr_neg,
  input  logic                    fire_ack,
  output logic                    row_req,
  output logic                    col_pos,
  output logic                    col_neg,
  output logic signed [ACC_W-1:0] acc_out
);

  logic             w_neg;
  logic [MAG_W-1:0] w_mag;
  logic             integ_go;
  logic             forget_go;
  logic             fire_pos;
  logic             fire_neg;

  // Pulses are gated while a request waits; integration outranks forgetting.
  assign integ_go  = integ_pulse & ~row_req;
  assign forget_go = forget & ~row_req & ~integ_pulse;

  lif_weight_reg #(.MAG_W(MAG_W)) u_wreg (
    .clk(clk), .rst_n(rst_n), .load(wt_load), .din(wt_in),
    .w_neg(w_neg), .w_mag(w_mag)
  );

  lif_integrator #(.ACC_W(ACC_W), .MAG_W(MAG_W), .LEAK_STEP(LEAK_STEP)) u_integ (
    .clk(clk), .rst_n(rst_n), .integ_go(integ_go), .forget_go(forget_go),
    .ev_neg(evt_neg), .w_neg(w_neg), .w_mag(w_mag),
    .thr_pos(thr_pos), .thr_neg(thr_neg),
    .acc(acc_out), .fire_pos(fire_pos), .fire_neg(fire_neg)
  );

  lif_fire_hs u_hs (
    .clk(clk), .rst_n(rst_n), .fire_pos(fire_pos), .fire_neg(fire_neg),
    .ack(fire_ack), .req(row_req), .col_pos(col_pos), .col_neg(col_neg)
  );

  AST_PEND_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    row_req |=> $stable(acc_out)); // R7
  AST_REST_AT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_req) |-> (acc_out == '0)); // R4
  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_req && !integ_pulse) |=> !row_req); // R10

endmodule

// File: tb/test_lif_pixel.sv
module test_lif_pixel;

  localparam int LEAK = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wt_load = 1'b0;
  logic [3:0] wt_in = '0;
  logic integ_pulse = 1'b0;
  logic evt_neg = 1'b0;
  logic forget = 1'b0;
  logic signed [15:0] thr_pos = 16'sd10;
  logic signed [15:0] thr_neg = -16'sd10;
  logic fire_ack = 1'b0;
  logic row_req, col_pos, col_neg;
  logic signed [15:0] acc_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Reference state
  int  m_acc = 0;
  bit  m_req = 0;
  bit  m_pos = 0;
  bit  m_wneg = 0;
  int  m_wmag = 0;

  always #4 clk = ~clk;

  lif_pixel i_lif_pixel (
    .clk(clk), .rst_n(rst_n), .wt_load(wt_load), .wt_in(wt_in),
    .integ_pulse(integ_pulse), .evt_neg(evt_neg), .forget(forget),
    .thr_pos(thr_pos), .thr_neg(thr_neg), .fire_ack(fire_ack),
    .row_req(row_req), .col_pos(col_pos), .col_neg(col_neg), .acc_out(acc_out)
  );

  function automatic int ref_leak(input int v);
    int mag = (v < 0) ? -v : v;
    int left = (mag <= LEAK) ? 0 : mag - LEAK;
    return (v < 0) ? -left : left;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input bit ld, input logic [3:0] w, input bit ig,
                            input bit en, input bit fg, input bit ak);
    if (m_req) begin
      if (ak) m_req = 0;
    end else if (ig) begin
      int v = m_acc + ((en ^ m_wneg) ? -m_wmag : m_wmag);
      if (v >= int'(thr_pos))      begin m_acc = 0; m_req = 1; m_pos = 1; end
      else if (v <= int'(thr_neg)) begin m_acc = 0; m_req = 1; m_pos = 0; end
      else m_acc = v;
    end else if (fg) begin
      m_acc = ref_leak(m_acc);
    end
    if (ld) begin m_wneg = w[3]; m_wmag = int'(w[2:0]); end
  endtask

  task automatic cyc(input string tag, input bit ld, input logic [3:0] w, input bit ig,
                     input bit en, input bit fg, input bit ak);
    wt_load = ld; wt_in = w; integ_pulse = ig; evt_neg = en; forget = fg; fire_ack = ak;
    @(posedge clk);
    model_step(ld, w, ig, en, fg, ak);
    #1;
    chk(tag, "acc_out", int'(acc_out), m_acc);
    chk(tag, "row_req", int'(row_req), int'(m_req));
    chk(tag, "col_pos", int'(col_pos), int'(m_req & m_pos));
    chk(tag, "col_neg", int'(col_neg), int'(m_req & ~m_pos));
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9", "acc_out", int'(acc_out), 0);
    chk("R9", "row_req", int'(row_req), 0);
    // Weight is +0 after reset: an integration leaves acc at 0.
    cyc("R9", 0, 4'h0, 1, 0, 0, 0);
    chk("R9", "acc_after_zero_weight", int'(acc_out), 0);

    // Positive weight, positive events: build up and fire positive.
    cyc("R1", 1, 4'b0011, 0, 0, 0, 0);
    cyc("R2", 0, 4'h0, 1, 0, 0, 0);
    cyc("R2", 0, 4'h0, 1, 0, 0, 0);
    cyc("R2", 0, 4'h0, 1, 0, 0, 0);
    chk("R2", "acc_sum", int'(acc_out), 9);
    cyc("R3", 0, 4'h0, 1, 0, 0, 0);
    chk("R3", "col_pos_fire", int'(col_pos), 1);
    chk("R4", "acc_rest", int'(acc_out), 0);
    cyc("R7", 0, 4'h0, 1, 0, 0, 0);
    cyc("R7", 0, 4'h0, 0, 0, 1, 0);
    chk("R7", "acc_frozen", int'(acc_out), 0);
    cyc("R6", 0, 4'h0, 0, 0, 0, 0);
    chk("R6", "req_held", int'(row_req), 1);
    cyc("R6", 0, 4'h0, 0, 0, 0, 1);
    chk("R6", "req_cleared", int'(row_req), 0);
    cyc("R10", 0, 4'h0, 0, 0, 0, 1);
    chk("R10", "req_idle_ack", int'(row_req), 0);

    // Negative weight, positive event: signs differ, subtract; fire negative.
    cyc("R1", 1, 4'b1101, 0, 0, 0, 0);
    cyc("R2", 0, 4'h0, 1, 0, 0, 0);
    chk("R2", "acc_sub", int'(acc_out), -5);
    cyc("R3", 0, 4'h0, 1, 0, 0, 0);
    chk("R3", "col_neg_fire", int'(col_neg), 1);
    cyc("R6", 0, 4'h0, 0, 0, 0, 1);

    // Leak with clamp on both sides.
    cyc("R1", 1, 4'b1011, 0, 0, 0, 0);
    cyc("R2", 0, 4'h0, 1, 1, 0, 0);
    chk("R2", "acc_same_neg", int'(acc_out), 3);
    cyc("R5", 0, 4'h0, 0, 0, 1, 0);
    cyc("R5", 0, 4'h0, 0, 0, 1, 0);
    chk("R5", "clamp_pos", int'(acc_out), 0);
    cyc("R5", 0, 4'h0, 0, 0, 1, 0);
    chk("R5", "rest_stays", int'(acc_out), 0);
    cyc("R5", 0, 4'h0, 1, 0, 0, 0);
    cyc("R5", 0, 4'h0, 0, 0, 1, 0);
    chk("R5", "leak_up", int'(acc_out), -1);
    cyc("R5", 0, 4'h0, 0, 0, 1, 0);
    chk("R5", "clamp_neg", int'(acc_out), 0);

    // Integration and forget together.
    cyc("R1", 1, 4'b0011, 0, 0, 0, 0);
    cyc("R8", 0, 4'h0, 1, 0, 1, 0);
    chk("R8", "integ_wins", int'(acc_out), 3);
    // Load in the same cycle as a pulse uses the old weight.
    cyc("R1", 1, 4'b0111, 1, 0, 0, 0);
    chk("R1", "old_weight_used", int'(acc_out), 6);
    cyc("R1", 0, 4'h0, 1, 0, 0, 0);
    chk("R1", "new_weight_fires", int'(col_pos), 1);
    cyc("R6", 0, 4'h0, 0, 0, 0, 1);

    // Random traffic in two threshold settings.
    for (int seg = 0; seg < 2; seg++) begin
      thr_pos = (seg == 0) ? 16'sd20 : 16'sd5;
      thr_neg = (seg == 0) ? -16'sd20 : -16'sd3;
      for (int i = 0; i < 1500; i++) begin
        cyc("R2/R3/R5/R6/R7 random",
            ($urandom % 10) < 3, 4'($urandom), ($urandom % 10) < 4,
            1'($urandom), ($urandom % 10) < 2, ($urandom % 10) < 3);
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule